// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This controller-side block drives the control strobes of a DRAM that keeps its most recently read row in an on-chip cache. After reset it holds row enable inactive for a power-up interval. It then runs the start-up sequence: a set of refresh cycles that use the memory's own row counter, followed by two reads to two different rows. Only after that does it raise a ready flag for the host.

In normal operation an interval counter adds one owed refresh every refresh period to a saturating debt counter. The sequencer repays that debt with refresh-select cycles. It never refreshes by reading a row, because a read that hits the cached row does not touch the array. At a cycle boundary an owed refresh wins over a host read or write. A cycle that has already started always runs to its end.

The host can also request self-refresh. The sequencer enters it with the dedicated strobe pattern and holds it until the request drops. It then keeps row enable high for a recovery time and issues one refresh at once, before any host cycle.

Top module: `rcd_refresh_seq`

## Requirements
- R1: From reset, row enable (`mem_re_n`) stays high and `host_ready` stays low. The first falling edge of row enable comes no earlier than PWRUP_CYC clock cycles after reset is released.
- R2: Start-up consists of exactly INIT_REF refresh cycles (INIT_REF at least 8), then one read to row INIT_ROW_A, then one read to row INIT_ROW_B (the two rows differ). `host_ready` rises only after the active period of the last of these ends, and once high it stays high until reset.
- R3: A refresh cycle holds `mem_ref_n` low, `mem_cs_n` low and both `mem_cal_n` and `mem_we_n` high for its whole active period. `mem_ref_n` is never low outside an active period, and no refresh is ever made by a read cycle.
- R4: Every cycle other than self-refresh holds row enable low for exactly ACT_CYC clocks. Between cycles, row enable stays high for at least PRE_CYC clocks.
- R5: Once ready, one refresh is owed every REF_INTERVAL clocks. Owed refreshes are kept in a counter that saturates at DEBT_MAX, and each one is repaid by a refresh cycle. Over a window of N intervals, N±1 refreshes are issued.
- R6: When the sequencer is idle and a refresh is owed, the refresh starts before a waiting host request. A host cycle in progress is never cut short, and a steady host load does not change the refresh rate of R5.
- R7: A host request (`host_req` held until `host_grant`) produces one cycle whose address is `host_row`, and `host_grant` pulses in the first active clock. For a read (`host_we`=0), `mem_wr` is low and `mem_cal_n` and `mem_we_n` are high. For a write (`host_we`=1), `mem_wr` is high, and `mem_cal_n` and `mem_we_n` are low in every active clock after the first.
- R8: A self-refresh request taken while idle, with nothing owed, holds row enable low with `mem_cs_n`, `mem_wr`, `mem_ref_n` and `mem_we_n` high and `mem_cal_n` low for as long as `sref_req` stays high.
- R9: After self-refresh ends, row enable stays high for at least SREF_PRE_CYC clocks. The next cycle is a refresh, even when a host request is waiting.
- R10: Row enable never falls while `mem_cs_n` is high, except on entry to self-refresh with the R8 pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host cycle request, held until granted |
| host_we | input | 1 | 1 = write, 0 = read |
| host_row | input | ROW_W | Row address of the host cycle |
| sref_req | input | 1 | Self-refresh request, level |
| host_grant | output | 1 | One-clock pulse when a host cycle starts |
| host_ready | output | 1 | Start-up sequence complete |
| mem_re_n | output | 1 | Row enable strobe, active low |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ref_n | output | 1 | Refresh select, active low |
| mem_wr | output | 1 | Write/read mode, high for write |
| mem_we_n | output | 1 | Write enable, active low |
| mem_cal_n | output | 1 | Column latch control, active low |
| mem_addr | output | ROW_W | Multiplexed address to the memory |

## Verification
The assertions assume that the host keeps `host_req`, `host_we` and `host_row` steady from request to grant, and that `sref_req` is raised only after start-up. The bench follows both rules: it drives every request and waits for the grant pulse before changing anything, and it requests self-refresh only once `host_ready` is high. It then queues a host read while self-refresh is still active, which makes the forced refresh of R9 visible at the ports. A passive monitor reconstructs each memory cycle from the strobes and checks every active and precharge interval arithmetically.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

   typedef enum logic [2:0] {
      ST_PWRUP    = 3'd0,
      ST_IDLE     = 3'd1,
      ST_ACT      = 3'd2,
      ST_PRE      = 3'd3,
      ST_SREF     = 3'd4,
      ST_SREF_REC = 3'd5
   } seq_state_e;

   typedef enum logic [1:0] {
      CK_REF = 2'd0,
      CK_RD  = 2'd1,
      CK_WR  = 2'd2
   } cyc_kind_e;

   function automatic int max_of4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/rfs_down_counter.sv
module rfs_down_counter #(
   parameter int W       = 4,
   parameter int RST_VAL = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);

   generate
      if (W < 1) begin : g_bad_w
         $error("rfs_down_counter: W must be at least 1");
      end
      if (RST_VAL >= (1 << W)) begin : g_bad_rst
         $error("rfs_down_counter: RST_VAL does not fit in W bits");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= W'(RST_VAL);
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

   AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (zero && !load) |=> zero);  // R4

endmodule

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer #(
   parameter int INTERVAL = 6250,
   parameter int DEBT_MAX = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic take,
   output logic owed
);

   localparam int IW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

   generate
      if (INTERVAL < 2) begin : g_bad_ivl
         $error("rfs_interval_timer: INTERVAL must be at least 2");
      end
      if (DEBT_MAX < 1) begin : g_bad_debt
         $error("rfs_interval_timer: DEBT_MAX must be at least 1");
      end
   endgenerate

   logic [IW-1:0] ivl_q;
   logic          tick;

   always_ff @(posedge clk) begin
      if (!rst_n || !run)
         ivl_q <= IW'(INTERVAL - 1);
      else if (ivl_q == '0)
         ivl_q <= IW'(INTERVAL - 1);
      else
         ivl_q <= ivl_q - 1'b1;
   end

   assign tick = run && (ivl_q == '0);

   generate
      if (DEBT_MAX == 1) begin : g_flag
         logic owed_q;
         always_ff @(posedge clk) begin
            if (!rst_n || !run)
               owed_q <= 1'b0;
            else if (tick)
               owed_q <= 1'b1;
            else if (take)
               owed_q <= 1'b0;
         end
         assign owed = owed_q;
      end else begin : g_count
         localparam int DW = $clog2(DEBT_MAX + 1);
         logic [DW-1:0] debt_q;
         logic [DW-1:0] after_take;

         always_comb after_take = debt_q - DW'(take);

         always_ff @(posedge clk) begin
            if (!rst_n || !run)
               debt_q <= '0;
            else if (tick && (after_take != DW'(DEBT_MAX)))
               debt_q <= after_take + 1'b1;
            else
               debt_q <= after_take;
         end
         assign owed = (debt_q != '0);

         AST_DEBT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            debt_q <= DW'(DEBT_MAX));  // R5
      end
   endgenerate

   AST_TAKE_WITH_DEBT: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> owed);  // R5

endmodule

// File: rtl/rfs_init_tracker.sv
module rfs_init_tracker
   import rfs_pkg::*;
#(
   parameter int ROW_W      = 11,
   parameter int INIT_REF   = 8,
   parameter int INIT_ROW_A = 0,
   parameter int INIT_ROW_B = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output cyc_kind_e        kind,
   output logic [ROW_W-1:0] row,
   output logic             done
);

   localparam int TOTAL = INIT_REF + 2;
   localparam int CW    = $clog2(TOTAL + 1);

   generate
      if (INIT_REF < 8) begin : g_bad_ref
         $error("rfs_init_tracker: at least eight start-up refreshes are needed");
      end
      if (INIT_ROW_A == INIT_ROW_B) begin : g_bad_rows
         $error("rfs_init_tracker: start-up reads need two different rows");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (step && !done)
         cnt_q <= cnt_q + 1'b1;
   end

   assign done = (cnt_q == CW'(TOTAL));
   assign kind = (cnt_q < CW'(INIT_REF)) ? CK_REF : CK_RD;
   assign row  = (cnt_q == CW'(INIT_REF)) ? ROW_W'(INIT_ROW_A) :
                 (cnt_q > CW'(INIT_REF))  ? ROW_W'(INIT_ROW_B) : '0;

   AST_NO_STEP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !step);  // R2

endmodule

// File: rtl/rcd_refresh_seq.sv
module rcd_refresh_seq
   import rfs_pkg::*;
#(
   parameter int ROW_W        = 11,
   parameter int PWRUP_CYC    = 30,
   parameter int ACT_CYC      = 4,
   parameter int PRE_CYC      = 3,
   parameter int SREF_PRE_CYC = 10,
   parameter int REF_INTERVAL = 6250,
   parameter int DEBT_MAX     = 4,
   parameter int INIT_REF     = 8,
   parameter int INIT_ROW_A   = 0,
   parameter int INIT_ROW_B   = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_req,
   input  logic             host_we,
   input  logic [ROW_W-1:0] host_row,
   input  logic             sref_req,
   output logic             host_grant,
   output logic             host_ready,
   output logic             mem_re_n,
   output logic             mem_cs_n,
   output logic             mem_ref_n,
   output logic             mem_wr,
   output logic             mem_we_n,
   output logic             mem_cal_n,
   output logic [ROW_W-1:0] mem_addr
);

   localparam int TMR_MAX = max_of4(PWRUP_CYC, ACT_CYC, PRE_CYC, SREF_PRE_CYC);
   localparam int TW      = $clog2(TMR_MAX + 1);

   generate
      if (ACT_CYC < 2) begin : g_bad_act
         $error("rcd_refresh_seq: ACT_CYC must be at least 2 for write strobes");
      end
      if (PRE_CYC < 1 || SREF_PRE_CYC < 1 || PWRUP_CYC < 1) begin : g_bad_pre
         $error("rcd_refresh_seq: precharge and power-up counts must be positive");
      end
      if (ROW_W < 2) begin : g_bad_row
         $error("rcd_refresh_seq: ROW_W too small");
      end
   endgenerate

   seq_state_e       st_q, st_d;
   cyc_kind_e        kind_q, kind_d;
   logic [ROW_W-1:0] row_q, row_d;
   logic             host_q, host_d;
   logic             first_q, first_d;
   logic             force_q, force_d;

   logic             tmr_load;
   logic [TW-1:0]    tmr_val;
   logic             tmr_zero;
   logic             take;
   logic             owed;
   logic             init_step;
   logic             init_done;
   cyc_kind_e        init_kind;
   logic [ROW_W-1:0] init_row;
   logic             in_sref;
   logic             timer_run;

   rfs_down_counter #(
      .W       (TW),
      .RST_VAL (PWRUP_CYC - 1)
   ) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   rfs_init_tracker #(
      .ROW_W      (ROW_W),
      .INIT_REF   (INIT_REF),
      .INIT_ROW_A (INIT_ROW_A),
      .INIT_ROW_B (INIT_ROW_B)
   ) u_init (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (init_step),
      .kind  (init_kind),
      .row   (init_row),
      .done  (init_done)
   );

   assign in_sref   = (st_q == ST_SREF) || (st_q == ST_SREF_REC);
   assign timer_run = init_done && !in_sref;

   rfs_interval_timer #(
      .INTERVAL (REF_INTERVAL),
      .DEBT_MAX (DEBT_MAX)
   ) u_ivl (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (timer_run),
      .take  (take),
      .owed  (owed)
   );

   // Next-state logic: arbitration happens only in ST_IDLE, so a
   // started cycle always completes its active and precharge phases.
   always_comb begin
      logic go;
      st_d      = st_q;
      kind_d    = kind_q;
      row_d     = row_q;
      host_d    = host_q;
      first_d   = 1'b0;
      force_d   = force_q;
      tmr_load  = 1'b0;
      tmr_val   = '0;
      take      = 1'b0;
      init_step = 1'b0;
      go        = 1'b0;

      unique case (st_q)
         ST_PWRUP: begin
            if (tmr_zero) st_d = ST_IDLE;
         end
         ST_IDLE: begin
            if (!init_done) begin
               go     = 1'b1;
               kind_d = init_kind;
               row_d  = init_row;
               host_d = 1'b0;
            end else if (force_q) begin
               go      = 1'b1;
               kind_d  = CK_REF;
               row_d   = '0;
               host_d  = 1'b0;
               force_d = 1'b0;
            end else if (owed) begin
               go     = 1'b1;
               take   = 1'b1;
               kind_d = CK_REF;
               row_d  = '0;
               host_d = 1'b0;
            end else if (sref_req) begin
               st_d = ST_SREF;
            end else if (host_req) begin
               go     = 1'b1;
               kind_d = host_we ? CK_WR : CK_RD;
               row_d  = host_row;
               host_d = 1'b1;
            end
            if (go) begin
               st_d     = ST_ACT;
               first_d  = 1'b1;
               tmr_load = 1'b1;
               tmr_val  = TW'(ACT_CYC - 1);
            end
         end
         ST_ACT: begin
            if (tmr_zero) begin
               st_d      = ST_PRE;
               tmr_load  = 1'b1;
               tmr_val   = TW'(PRE_CYC - 1);
               init_step = !init_done;
               host_d    = 1'b0;
            end
         end
         ST_PRE: begin
            if (tmr_zero) st_d = ST_IDLE;
         end
         ST_SREF: begin
            if (!sref_req) begin
               st_d     = ST_SREF_REC;
               tmr_load = 1'b1;
               tmr_val  = TW'(SREF_PRE_CYC - 1);
            end
         end
         ST_SREF_REC: begin
            if (tmr_zero) begin
               st_d    = ST_IDLE;
               force_d = 1'b1;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_PWRUP;
         kind_q  <= CK_REF;
         row_q   <= '0;
         host_q  <= 1'b0;
         first_q <= 1'b0;
         force_q <= 1'b0;
      end else begin
         st_q    <= st_d;
         kind_q  <= kind_d;
         row_q   <= row_d;
         host_q  <= host_d;
         first_q <= first_d;
         force_q <= force_d;
      end
   end

   // Strobes decode from registered state only.
   logic act;
   logic wr_strobe;
   assign act       = (st_q == ST_ACT);
   assign wr_strobe = act && (kind_q == CK_WR) && !first_q;

   assign mem_re_n   = !(act || (st_q == ST_SREF));
   assign mem_cs_n   = (st_q == ST_PWRUP) || in_sref;
   assign mem_ref_n  = !(act && (kind_q == CK_REF));
   assign mem_wr     = (act && (kind_q == CK_WR)) || (st_q == ST_SREF);
   assign mem_we_n   = !wr_strobe;
   assign mem_cal_n  = !(wr_strobe || (st_q == ST_SREF));
   assign mem_addr   = act ? row_q : '0;
   assign host_grant = act && first_q && host_q;
   assign host_ready = init_done;

   AST_FALL_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_re_n) |-> (!mem_cs_n || (!mem_cal_n && mem_wr && mem_ref_n && mem_we_n)));  // R10

   AST_REF_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_re_n && !$fell(mem_re_n) && !mem_cs_n) |-> (mem_ref_n == $past(mem_ref_n)));  // R3

   AST_REF_NOT_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_ref_n |-> (!mem_re_n && !mem_cs_n && mem_cal_n && mem_we_n));  // R3

   AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_re_n) |=> mem_re_n);  // R4

   AST_GRANT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      host_grant |-> (host_ready && $past(host_req)));  // R7

   AST_READY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      $past(host_ready) |-> host_ready);  // R2

   AST_FORCED_REF: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SREF_REC && tmr_zero) |=> ##1 (st_q == ST_ACT && kind_q == CK_REF));  // R9

   AST_SREF_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_cs_n && !mem_re_n) |-> (mem_wr && mem_ref_n && mem_we_n && !mem_cal_n));  // R8

endmodule

// File: tb/tb_rcd_refresh_seq.sv
module tb_rcd_refresh_seq;

   localparam int CLK_PERIOD = 10;
   localparam int ROW_W      = 4;
   localparam int PWRUP      = 5;
   localparam int ACT        = 2;
   localparam int PRE        = 2;
   localparam int SREFPRE    = 4;
   localparam int INTV       = 40;
   localparam int DEBT       = 3;
   localparam int INITREF    = 8;
   localparam int WATCHDOG   = 20000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             host_req = 1'b0;
   logic             host_we = 1'b0;
   logic [ROW_W-1:0] host_row = '0;
   logic             sref_req = 1'b0;
   logic             host_grant, host_ready;
   logic             mem_re_n, mem_cs_n, mem_ref_n, mem_wr, mem_we_n, mem_cal_n;
   logic [ROW_W-1:0] mem_addr;

   rcd_refresh_seq #(
      .ROW_W(ROW_W), .PWRUP_CYC(PWRUP), .ACT_CYC(ACT), .PRE_CYC(PRE),
      .SREF_PRE_CYC(SREFPRE), .REF_INTERVAL(INTV), .DEBT_MAX(DEBT),
      .INIT_REF(INITREF), .INIT_ROW_A(0), .INIT_ROW_B(1)
   ) dut (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
      .host_row(host_row), .sref_req(sref_req), .host_grant(host_grant),
      .host_ready(host_ready), .mem_re_n(mem_re_n), .mem_cs_n(mem_cs_n),
      .mem_ref_n(mem_ref_n), .mem_wr(mem_wr), .mem_we_n(mem_we_n),
      .mem_cal_n(mem_cal_n), .mem_addr(mem_addr)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int vec = 0;
   int bad = 0;
   bit finished = 1'b0;

   // cycle types: 0 refresh, 1 read, 2 write, 3 self-refresh
   int lg_type [0:1023];
   int lg_row  [0:1023];
   int n_log = 0;
   int exp_t [0:255];
   int exp_r [0:255];
   int n_exp = 0;
   int cyc = 0;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      vec++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   endtask

   // Passive monitor: rebuilds memory cycles from the strobes.
   bit prev_re = 1'b1;
   int hi_len = 0;
   int lo_len = 0;
   int cur_t = 0;
   int cur_row = 0;
   bit last_sref = 1'b0;

   always @(negedge clk) begin
      int t;
      if (rst_n) begin
         cyc++;
         if (prev_re && !mem_re_n) begin
            t = mem_cs_n ? 3 : (!mem_ref_n ? 0 : (mem_wr ? 2 : 1));
            if (n_log == 0)
               chk(hi_len >= PWRUP, "R1 power-up hold", hi_len, PWRUP);
            else if (last_sref)
               chk(hi_len >= SREFPRE, "R9 recovery hold", hi_len, SREFPRE);
            else
               chk(hi_len >= PRE, "R4 precharge", hi_len, PRE);
            if (mem_cs_n)
               chk(mem_wr && mem_ref_n && mem_we_n && !mem_cal_n, "R10 fall while deselected", 0, 1);
            if (t == 0)
               chk(mem_cal_n && mem_we_n, "R3 refresh strobes", {mem_cal_n, mem_we_n}, 3);
            if (n_log < 1024) begin
               lg_type[n_log] = t;
               lg_row[n_log]  = int'(mem_addr);
               n_log++;
            end
            cur_t = t;
            cur_row = int'(mem_addr);
            lo_len = 1;
            last_sref = (t == 3);
         end else if (!mem_re_n) begin
            lo_len++;
            case (cur_t)
               0: chk(!mem_ref_n && !mem_cs_n && mem_cal_n && mem_we_n, "R3 refresh held", 0, 1);
               1: chk(mem_cal_n && mem_we_n && !mem_wr && int'(mem_addr) == cur_row, "R7 read strobes", int'(mem_addr), cur_row);
               2: chk(!mem_cal_n && !mem_we_n && mem_wr && int'(mem_addr) == cur_row, "R7 write strobes", int'(mem_addr), cur_row);
               default: chk(mem_cs_n && !mem_cal_n && mem_wr, "R8 self-refresh held", 0, 1);
            endcase
         end
         if (!prev_re && mem_re_n) begin
            if (cur_t != 3) chk(lo_len == ACT, "R4 active length", lo_len, ACT);
            hi_len = 1;
         end else if (mem_re_n) begin
            hi_len++;
         end
         prev_re = mem_re_n;
      end
   end

   task automatic host_op(input bit we, input int row);
      @(negedge clk);
      host_req = 1'b1;
      host_we  = we;
      host_row = ROW_W'(row);
      do @(negedge clk); while (!host_grant);
      host_req = 1'b0;
      exp_t[n_exp] = we ? 2 : 1;
      exp_r[n_exp] = row;
      n_exp++;
   endtask

   function automatic int count_refs(input int from, input int to);
      int c = 0;
      for (int i = from; i < to; i++) if (lg_type[i] == 0) c++;
      return c;
   endfunction

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         vec++;
         bad++;
         $display("FAIL R4 watchdog actual=hung expected=done");
         finish_run();
      end
   end

   initial begin
      int s, t0, nref, expn, k, j;
      repeat (3) @(negedge clk);
      chk(mem_re_n == 1'b1, "R1 reset row enable", mem_re_n, 1);
      chk(host_ready == 1'b0, "R1 reset ready", host_ready, 0);
      rst_n = 1'b1;

      // R2: start-up sequence
      while (!host_ready) @(negedge clk);
      chk(n_log == INITREF + 2, "R2 start-up cycle count", n_log, INITREF + 2);
      for (int i = 0; i < INITREF; i++)
         chk(lg_type[i] == 0, "R2 start-up refresh", lg_type[i], 0);
      chk(lg_type[INITREF] == 1 && lg_row[INITREF] == 0, "R2 first read row", lg_row[INITREF], 0);
      chk(lg_type[INITREF+1] == 1 && lg_row[INITREF+1] == 1, "R2 second read row", lg_row[INITREF+1], 1);

      // R5: idle refresh rate
      s = n_log;
      repeat (10 * INTV) @(negedge clk);
      nref = count_refs(s, n_log);
      chk(nref >= 9 && nref <= 11, "R5 idle refresh rate", nref, 10);
      chk(n_log - s == nref, "R5 only refresh while idle", n_log - s, nref);

      // R7: sweep all rows for reads and writes
      for (int we = 0; we < 2; we++)
         for (int r = 0; r < (1 << ROW_W); r++)
            host_op(we[0], r);

      // R6: steady host load keeps the refresh rate
      s = n_log;
      t0 = cyc;
      k = 0;
      while (cyc - t0 < 10 * INTV) begin
         host_op(k[0], (k * 5) % (1 << ROW_W));
         k++;
      end
      nref = count_refs(s, n_log);
      expn = (cyc - t0) / INTV;
      chk(nref >= expn - 1 && nref <= expn + 1, "R6 refresh under host load", nref, expn);

      // R8 / R9: self-refresh with a host read waiting
      @(negedge clk);
      sref_req = 1'b1;
      while (n_log == 0 || lg_type[n_log-1] != 3) @(negedge clk);
      k = n_log - 1;
      repeat (20) @(negedge clk);
      chk(!mem_re_n && mem_cs_n, "R8 self-refresh held low", mem_re_n, 0);
      host_req = 1'b1;
      host_we  = 1'b0;
      host_row = ROW_W'(5);
      @(negedge clk);
      sref_req = 1'b0;
      do @(negedge clk); while (!host_grant);
      host_req = 1'b0;
      exp_t[n_exp] = 1;
      exp_r[n_exp] = 5;
      n_exp++;
      repeat (10) @(negedge clk);
      chk(lg_type[k+1] == 0, "R9 refresh after exit", lg_type[k+1], 0);
      chk(lg_type[k+2] == 1 && lg_row[k+2] == 5, "R9 host after refresh", lg_row[k+2], 5);

      // R7: every host request appears once, in order
      j = 0;
      for (int i = INITREF + 2; i < n_log; i++) begin
         if (lg_type[i] == 1 || lg_type[i] == 2) begin
            chk(lg_type[i] == exp_t[j] && lg_row[i] == exp_r[j], "R7 host cycle", lg_row[i], exp_r[j]);
            j++;
         end
      end
      chk(j == n_exp, "R7 host cycle count", j, n_exp);
      finish_run();
   end

endmodule